// File: doc/BRIEF.md
# Skewed Two-Way Tag Store

This block is the tag side of a two-way cache in which each way picks its set with its own XOR hash of the block address. The two ways do not share plain index bits. Two blocks that land on the same set in one way are usually spread apart in the other. This keeps conflict misses down without adding more ways.

A lookup is presented with a block address and a read/write flag. Both ways are probed in the same cycle, each at its own hashed set. The response arrives combinationally in that cycle. It gives hit or miss and a way. On a hit that way is the one holding the block. On a miss it is the way chosen for replacement. The response also gives the set number inside that way, which the surrounding data array uses as its address.

A miss whose victim is dirty raises a write-back request carrying the evicted block address. A separate fill port installs a block into a chosen way at its hashed set. The install takes effect at the next clock edge. Data storage and the refill path sit outside the block.

Top module: `skew_tag_store`

## Requirements
- R1: After reset every entry is invalid. While req_valid is low, resp_hit, resp_miss and wb_valid are 0. A lookup right after reset misses, and its victim is way 0.
- R2: Way 0 probes set `blk[3:0] ^ blk[7:4]`, where blk is the block address. On a hit in way 0, or a miss whose victim is way 0, resp_set carries this value.
- R3: Way 1 probes set `blk[3:0] ^ rev(blk[7:4])`, where rev swaps bit order (bit 0 becomes bit 3). resp_set carries this value whenever resp_way is 1.
- R4: A lookup hits only when an entry at the probed set of some way is valid and its stored tag equals the whole block address. resp_way (0 or 1) then names that way. resp_hit and resp_miss are never both high.
- R5: On a miss, the victim is chosen as follows. If the way-0 candidate is invalid, way 0 is the victim. Otherwise, if the way-1 candidate is invalid, way 1 is the victim. Otherwise the victim is way 1 when the way-0 candidate's recency bit is set, and way 0 when it is clear.
- R6: A hit or a fill sets the recency bit of the entry it touches. It clears the recency bit of the entry that the same block address selects in the other way.
- R7: A write hit marks the entry dirty. A read hit leaves the dirty bit unchanged. A miss changes no entry.
- R8: wb_valid is high exactly on a miss whose victim entry is valid and dirty. wb_blk then carries that entry's block address.
- R9: A fill writes valid=1, dirty=fill_dirty and the tag into set hash(fill_blk) of way fill_way at the next edge. A lookup in the same cycle sees the old contents. If a write hit and a fill touch the same entry in one cycle, the fill's contents win.
- R10: A block lives in at most one way. A fill invalidates a copy of the same block held at its hashed set in the other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_blk | input | 28 | Block address to look up |
| req_write | input | 1 | Lookup is a write |
| resp_hit | output | 1 | Lookup hit |
| resp_miss | output | 1 | Lookup missed |
| resp_way | output | 1 | Hit way, or victim way on a miss |
| resp_set | output | 4 | Set index inside resp_way |
| wb_valid | output | 1 | Dirty victim must be written back |
| wb_blk | output | 28 | Block address of the dirty victim |
| fill_valid | input | 1 | Install request |
| fill_blk | input | 28 | Block address to install |
| fill_way | input | 1 | Way to install into |
| fill_dirty | input | 1 | Dirty state of the installed block |

## Verification
A lookup and a fill can occur in the same cycle. They may even target the same entry, or the two copies of one block in different ways. The bench drives a write hit on an entry while a fill overwrites that same entry with a clean block. It checks three things: the response in that cycle reflects the old contents, the next lookup finds the new block, and a later eviction of that block raises no write-back. Randomized traffic also mixes fills with lookups to colliding addresses. A reference model applies lookup effects before fill effects.

// File: rtl/skew_cache_pkg.sv
package skew_cache_pkg;
    localparam int ADDR_W   = 32;
    localparam int OFFS_W   = 4;
    localparam int IDX_W    = 4;
    localparam int NUM_WAYS = 2;
    localparam int BLK_W    = ADDR_W - OFFS_W;
    localparam int NUM_SETS = 1 << IDX_W;
    localparam int KEY_W    = 2 * IDX_W;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [KEY_W-1:0] key_t;
    typedef logic             way_t;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic recent;
        blk_t tag;
    } line_t;

    // reverse the bit order of an index-wide field
    function automatic idx_t mirror_idx(input idx_t x);
        idx_t r;
        for (int i = 0; i < IDX_W; i++) begin
            r[i] = x[IDX_W-1-i];
        end
        return r;
    endfunction

    function automatic idx_t key_low(input key_t k);
        return k[IDX_W-1:0];
    endfunction

    function automatic idx_t key_high(input key_t k);
        return k[KEY_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/skew_set_hash.sv
module skew_set_hash
    import skew_cache_pkg::*;
#(
    parameter int WAY_ID = 0
) (
    input  key_t key,
    output idx_t set_idx
);
    generate
        if (WAY_ID == 0) begin : g_plain
            assign set_idx = key_low(key) ^ key_high(key);
        end else begin : g_mirrored
            assign set_idx = key_low(key) ^ mirror_idx(key_high(key));
        end
    endgenerate
endmodule

// File: rtl/skew_way_array.sv
module skew_way_array
    import skew_cache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    // lookup side
    input  idx_t  lk_set,
    output line_t lk_line,
    input  logic  lk_touch,
    input  logic  lk_mark_dirty,
    input  logic  lk_age,
    // fill side
    input  idx_t  fl_set,
    input  blk_t  fl_tag,
    output logic  fl_holds,
    input  logic  fl_install,
    input  logic  fl_dirty,
    input  logic  fl_age,
    input  logic  fl_drop
);
    line_t mem_q [NUM_SETS];

    assign lk_line  = mem_q[lk_set];
    assign fl_holds = mem_q[fl_set].valid && (mem_q[fl_set].tag == fl_tag);

    // lookup effects first, fill effects later so the fill wins on overlap
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SETS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (lk_touch) begin
                mem_q[lk_set].recent <= 1'b1;
                if (lk_mark_dirty) begin
                    mem_q[lk_set].dirty <= 1'b1;
                end
            end
            if (lk_age) begin
                mem_q[lk_set].recent <= 1'b0;
            end
            if (fl_age) begin
                mem_q[fl_set].recent <= 1'b0;
            end
            if (fl_drop) begin
                mem_q[fl_set].valid <= 1'b0;
            end
            if (fl_install) begin
                mem_q[fl_set] <= '{valid: 1'b1, dirty: fl_dirty, recent: 1'b1, tag: fl_tag};
            end
        end
    end
endmodule

// File: rtl/skew_victim_pick.sv
module skew_victim_pick
    import skew_cache_pkg::*;
(
    input  logic [NUM_WAYS-1:0] cand_valid,
    input  logic [NUM_WAYS-1:0] cand_recent,
    output way_t                victim
);
    always_comb begin
        if (!cand_valid[0]) begin
            victim = 1'b0;
        end else if (!cand_valid[1]) begin
            victim = 1'b1;
        end else begin
            victim = cand_recent[0];
        end
    end
endmodule

// File: rtl/skew_tag_store.sv
module skew_tag_store
    import skew_cache_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [BLK_W-1:0]      req_blk,
    input  logic                  req_write,
    output logic                  resp_hit,
    output logic                  resp_miss,
    output logic                  resp_way,
    output logic [IDX_W-1:0]      resp_set,
    output logic                  wb_valid,
    output logic [BLK_W-1:0]      wb_blk,
    input  logic                  fill_valid,
    input  logic [BLK_W-1:0]      fill_blk,
    input  logic                  fill_way,
    input  logic                  fill_dirty
);
    idx_t                lk_set   [NUM_WAYS];
    idx_t                fl_set   [NUM_WAYS];
    line_t               lk_line  [NUM_WAYS];
    logic [NUM_WAYS-1:0] lk_match;
    logic [NUM_WAYS-1:0] fl_holds;
    logic [NUM_WAYS-1:0] cand_valid;
    logic [NUM_WAYS-1:0] cand_recent;
    way_t                victim;
    logic                any_hit;
    line_t               victim_line;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        localparam int OTHER = NUM_WAYS - 1 - g;

        skew_set_hash #(.WAY_ID(g)) i_lk_hash (
            .key     (req_blk[KEY_W-1:0]),
            .set_idx (lk_set[g])
        );

        skew_set_hash #(.WAY_ID(g)) i_fl_hash (
            .key     (fill_blk[KEY_W-1:0]),
            .set_idx (fl_set[g])
        );

        assign lk_match[g]    = req_valid && lk_line[g].valid && (lk_line[g].tag == req_blk);
        assign cand_valid[g]  = lk_line[g].valid;
        assign cand_recent[g] = lk_line[g].recent;

        skew_way_array i_array (
            .clk           (clk),
            .rst           (rst),
            .lk_set        (lk_set[g]),
            .lk_line       (lk_line[g]),
            .lk_touch      (lk_match[g]),
            .lk_mark_dirty (req_write),
            .lk_age        (lk_match[OTHER]),
            .fl_set        (fl_set[g]),
            .fl_tag        (fill_blk),
            .fl_holds      (fl_holds[g]),
            .fl_install    (fill_valid && (fill_way == way_t'(g))),
            .fl_dirty      (fill_dirty),
            .fl_age        (fill_valid && (fill_way != way_t'(g))),
            .fl_drop       (fill_valid && (fill_way != way_t'(g)) && fl_holds[g])
        );
    end

    skew_victim_pick i_victim (
        .cand_valid  (cand_valid),
        .cand_recent (cand_recent),
        .victim      (victim)
    );

    assign any_hit     = |lk_match;
    assign victim_line = lk_line[victim];

    assign resp_hit  = any_hit;
    assign resp_miss = req_valid && !any_hit;
    assign resp_way  = any_hit ? lk_match[1] : victim;
    assign resp_set  = lk_set[resp_way];
    assign wb_valid  = resp_miss && victim_line.valid && victim_line.dirty;
    assign wb_blk    = victim_line.tag;
endmodule

// File: rtl/skew_tag_store_chk.sv
module skew_tag_store_chk
    import skew_cache_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [BLK_W-1:0] req_blk,
    input logic             req_write,
    input logic             resp_hit,
    input logic             resp_miss,
    input logic             resp_way,
    input logic             wb_valid,
    input logic [BLK_W-1:0] fill_blk,
    input logic             fill_valid,
    input logic             fill_way
);
    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && req_valid) |-> resp_miss);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!resp_hit && !resp_miss && !wb_valid));

    assert_single_result_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (resp_hit != resp_miss));

    assert_write_hit_stays_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && resp_hit && !fill_valid) |=>
        (!req_valid || (req_blk != $past(req_blk)) || resp_hit));

    assert_wb_only_on_miss_R8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> resp_miss);

    assert_fill_lands_R9: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=>
        (!req_valid || (req_blk != $past(fill_blk)) || (resp_hit && (resp_way == $past(fill_way)))));
endmodule

bind skew_tag_store skew_tag_store_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_blk    (req_blk),
    .req_write  (req_write),
    .resp_hit   (resp_hit),
    .resp_miss  (resp_miss),
    .resp_way   (resp_way),
    .wb_valid   (wb_valid),
    .fill_blk   (fill_blk),
    .fill_valid (fill_valid),
    .fill_way   (fill_way)
);

// File: tb/test_skew_tag_store.sv
module test_skew_tag_store;
    localparam int BW = 28;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [BW-1:0] req_blk = '0;
    logic          req_write = 1'b0;
    logic          resp_hit, resp_miss, resp_way, wb_valid;
    logic [3:0]    resp_set;
    logic [BW-1:0] wb_blk;
    logic          fill_valid = 1'b0;
    logic [BW-1:0] fill_blk = '0;
    logic          fill_way = 1'b0;
    logic          fill_dirty = 1'b0;

    always #4 clk = ~clk;

    skew_tag_store i_skew_tag_store (.*);

    typedef struct {
        bit          chk;
        bit          hit;
        bit          way;
        logic [3:0]  set;
        bit          wb;
        logic [BW-1:0] wbb;
        string       rq;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    bit            mv [2][16];
    bit            md [2][16];
    bit            mr [2][16];
    logic [BW-1:0] mt [2][16];

    function automatic logic [3:0] hsh(input logic [BW-1:0] b, input bit w);
        logic [3:0] hi = b[7:4];
        if (w) hi = {hi[0], hi[1], hi[2], hi[3]};
        return b[3:0] ^ hi;
    endfunction

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic step(input bit rv, input logic [BW-1:0] rb, input bit rw,
                        input bit fv, input logic [BW-1:0] fb, input bit fw, input bit fd,
                        input string rq);
        exp_t e;
        logic [3:0] s [2];
        bit m [2];
        bit vic;
        @(negedge clk);
        req_valid = rv; req_blk = rb; req_write = rw;
        fill_valid = fv; fill_blk = fb; fill_way = fw; fill_dirty = fd;
        for (int w = 0; w < 2; w++) begin
            s[w] = hsh(rb, w[0]);
            m[w] = rv && mv[w][s[w]] && (mt[w][s[w]] == rb);
        end
        if (!mv[0][s[0]]) vic = 0;
        else if (!mv[1][s[1]]) vic = 1;
        else vic = mr[0][s[0]];
        e.chk = rv;
        e.hit = m[0] || m[1];
        e.way = e.hit ? m[1] : vic;
        e.set = s[e.way];
        e.wb  = rv && !e.hit && mv[vic][s[vic]] && md[vic][s[vic]];
        e.wbb = mt[vic][s[vic]];
        e.rq  = rq;
        sb.push_back(e);
        // lookup effects
        for (int w = 0; w < 2; w++) begin
            if (m[w]) begin
                mr[w][s[w]] = 1;
                if (rw) md[w][s[w]] = 1;
                mr[1-w][s[1-w]] = 0;
            end
        end
        // fill effects, applied after
        if (fv) begin
            int o = fw ? 0 : 1;
            logic [3:0] so = hsh(fb, o[0]);
            logic [3:0] sf = hsh(fb, fw);
            mr[o][so] = 0;
            if (mv[o][so] && mt[o][so] == fb) mv[o][so] = 0;
            mv[fw][sf] = 1; md[fw][sf] = fd; mr[fw][sf] = 1; mt[fw][sf] = fb;
        end
    endtask

    task automatic look(input logic [BW-1:0] b, input bit w, input string rq);
        step(1, b, w, 0, '0, 0, 0, rq);
    endtask

    task automatic fill(input logic [BW-1:0] b, input bit w, input bit d, input string rq);
        step(0, '0, 0, 1, b, w, d, rq);
    endtask

    // monitor: compares design results against the scoreboard
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                if (e.chk) begin
                    check(e.rq, "hit", resp_hit, e.hit);
                    check(e.rq, "miss", resp_miss, !e.hit);
                    check(e.rq, "way", resp_way, e.way);
                    check(e.rq, "set", resp_set, e.set);
                    check(e.rq, "wb_valid", wb_valid, e.wb);
                    if (e.wb) check(e.rq, "wb_blk", wb_blk, e.wbb);
                end else begin
                    check(e.rq, "idle hit", resp_hit, 0);
                    check(e.rq, "idle miss", resp_miss, 0);
                    check(e.rq, "idle wb", wb_valid, 0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    localparam logic [BW-1:0] A = 28'h35;     // sets: way0 6, way1 9
    localparam logic [BW-1:0] B = 28'h12;     // sets: way0 3, way1 A
    localparam logic [BW-1:0] C = 28'h1035;   // same sets as A
    localparam logic [BW-1:0] D = 28'h2035;   // same sets as A
    localparam logic [BW-1:0] E = 28'h3035;   // same sets as A

    initial begin
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 16; i++) begin
                mv[w][i] = 0; md[w][i] = 0; mr[w][i] = 0; mt[w][i] = '0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        step(0, '0, 0, 0, '0, 0, 0, "R1");
        look(A, 0, "R1");
        fill(A, 0, 0, "R9");
        look(A, 0, "R2");
        step(1, B, 0, 1, B, 1, 0, "R9");
        look(B, 0, "R3");
        look(C, 0, "R4");
        look(A, 1, "R7");
        fill(C, 1, 0, "R9");
        look(D, 0, "R8");
        look(A, 0, "R7");
        look(D, 0, "R6");
        fill(A, 1, 1, "R10");
        look(A, 0, "R10");
        look(C, 0, "R10");
        step(1, A, 1, 1, C, 1, 0, "R9");
        look(C, 0, "R9");
        fill(D, 0, 0, "R9");
        look(D, 0, "R6");
        look(E, 0, "R9");
        look(E, 0, "R5");
        for (int k = 0; k < 600; k++) begin
            logic [BW-1:0] rb = BW'(($urandom % 4) << 12) | BW'($urandom % 64);
            logic [BW-1:0] fb = BW'(($urandom % 4) << 12) | BW'($urandom % 64);
            bit fv = ($urandom % 3) == 0;
            step(($urandom % 4) != 0, rb, $urandom % 2, fv, fb, $urandom % 2, $urandom % 2, "R5");
        end
        step(0, '0, 0, 0, '0, 0, 0, "R1");
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule